// File: doc/BRIEF.md
# Timer Event Flag Register

This block holds the pending-event flags of a 16-bit timer/counter and turns them into interrupt requests. Four events are tracked: input capture, compare-match on channel A, compare-match on channel B, and counter overflow. Each event flag is set by hardware and stays set until it is cleared. It can be cleared by a per-flag interrupt acknowledge pulse, or by software writing a one to its bit. The counter, the waveform generator, the capture latch and the pin logic are outside the block. It only observes their values and strobes.

Every set event is qualified by the timer clock enable. Compare flags are delayed by one such enable after the counter equals the compare value. Each compare channel does this with a two-state machine. `CMP_IDLE` moves to `CMP_ARMED` when an enabled tick sees equality. `CMP_ARMED` raises the set pulse on the next enabled tick. From there it returns to `CMP_IDLE`, or stays in `CMP_ARMED` if equality holds again. Each flag bit is a two-state machine of its own. `FLAG_CLEAR` moves to `FLAG_SET` on a set event. `FLAG_SET` moves to `FLAG_CLEAR` on a clear with no simultaneous set. A mode input selects the capture-flag source. It is either the external capture strobe, or the counter reaching the capture value when that value serves as the counter top.

Top module: `timer_flag_reg`

## Requirements
- R1: After reset, `flags` reads 8'h00 and `irq` reads 4'h0. Capture is bit 5, compare-B is bit 2, compare-A is bit 1 and overflow is bit 0.
- R2: Bits 7, 6, 4 and 3 of `flags` always read zero, and writing ones to them changes nothing.
- R3: With `top_is_cap` low, a `cap_evt` on an enabled tick sets bit 5.
- R4: With `top_is_cap` high, bit 5 sets on an enabled tick where `count` equals `cap_value`, and `cap_evt` is ignored.
- R5: A compare flag (bit 1 for `cmp_a`, bit 2 for `cmp_b`) is not set by the enabled tick that sees equality. It sets on the next enabled tick, and ticks that are not enabled do not count.
- R6: `force_a` and `force_b` never set bit 1 or bit 2.
- R7: An `ovf_evt` on an enabled tick sets bit 0.
- R8: A pulse on `ack` clears its flag. The `ack` bit order is [3]=capture, [2]=compare-B, [1]=compare-A, [0]=overflow.
- R9: A write (`wr_en` high) with a one in bit 5, 2, 1 or 0 of `wr_data` clears that flag, and a zero leaves it unchanged.
- R10: When a set event and a clear for the same flag meet in one cycle, the flag ends up set.
- R11: While `tick` is low, no flag becomes set.
- R12: `irq[i]` equals the flag in `ack` bit order i ANDed with `irq_mask[i]`, so a request appears in the cycle after the flag's set event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| count | input | 16 | Current counter value |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| cap_value | input | 16 | Capture register value (counter top in capture-top mode) |
| top_is_cap | input | 1 | Mode: capture register serves as counter top |
| cap_evt | input | 1 | Capture event strobe |
| ovf_evt | input | 1 | Counter overflow strobe |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| ack | input | 4 | Per-flag interrupt acknowledge pulses |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| irq_mask | input | 4 | Interrupt enable mask, ack bit order |
| flags | output | 8 | Flag register read value |
| irq | output | 4 | Masked interrupt requests |

## Verification
A compare machine stuck in `CMP_ARMED`, or one that skips it, shows on `flags` within one enabled tick of an equality. The flag either appears in the equality cycle itself, or it never appears. A flag machine that mishandles the clear path shows on the very next clock, as a bit that survives an acknowledge or a write of one, or as a bit lost when a set coincides with a clear. Because `irq` follows the flags directly, any flag error is also visible on the request lines in the same cycle, as long as the mask bit is set.

// File: rtl/timer_flag_pkg.sv
package timer_flag_pkg;
    // flag positions in the acknowledge / request vectors
    localparam int FI_OVF = 0;
    localparam int FI_CMPA = 1;
    localparam int FI_CMPB = 2;
    localparam int FI_CAP = 3;
    localparam int NUM_FLAGS = 4;

    // bit positions in the 8-bit register image
    localparam int RB_OVF = 0;
    localparam int RB_CMPA = 1;
    localparam int RB_CMPB = 2;
    localparam int RB_CAP = 5;
    localparam int REG_W = 8;

    typedef enum logic {
        CMP_IDLE = 1'b0,
        CMP_ARMED = 1'b1
    } cmp_state_t;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET = 1'b1
    } flag_state_t;
endpackage

// File: rtl/cmp_match_fsm.sv
module cmp_match_fsm
    import timer_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_val,
    output logic         set_o
);
    cmp_state_t state_q, state_d;
    logic       eq;

    assign eq = (count == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_IDLE:  if (tick && eq) state_d = CMP_ARMED;
            CMP_ARMED: if (tick) state_d = eq ? CMP_ARMED : CMP_IDLE;
            default:   state_d = CMP_IDLE;
        endcase
    end

    always_comb begin
        set_o = 1'b0;
        unique case (state_q)
            CMP_IDLE:  set_o = 1'b0;
            CMP_ARMED: set_o = tick;
            default:   set_o = 1'b0;
        endcase
    end

    // R5
    eq_cycle_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMP_IDLE) |-> !set_o);
endmodule

// File: rtl/flag_cell.sv
module flag_cell
    import timer_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_i) state_d = FLAG_SET;
            FLAG_SET:   if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = 1'b0;
        unique case (state_q)
            FLAG_CLEAR: flag_o = 1'b0;
            FLAG_SET:   flag_o = 1'b1;
            default:    flag_o = 1'b0;
        endcase
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R9
    hold_without_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/timer_flag_reg.sv
module timer_flag_reg
    import timer_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [W-1:0]         count,
    input  logic [W-1:0]         cmp_a,
    input  logic [W-1:0]         cmp_b,
    input  logic [W-1:0]         cap_value,
    input  logic                 top_is_cap,
    input  logic                 cap_evt,
    input  logic                 ovf_evt,
    input  logic                 force_a,
    input  logic                 force_b,
    input  logic [NUM_FLAGS-1:0] ack,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [NUM_FLAGS-1:0] irq_mask,
    output logic [REG_W-1:0]     flags,
    output logic [NUM_FLAGS-1:0] irq
);
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] wr_clr;
    logic [NUM_FLAGS-1:0] flag_vec;
    logic [1:0]           cmp_set;
    logic [W-1:0]         cmp_vals [2];
    logic                 cap_src;
    logic                 unused_inputs;

    assign cmp_vals[0] = cmp_a;
    assign cmp_vals[1] = cmp_b;

    // force strobes and reserved write bits deliberately reach no flag
    assign unused_inputs = ^{force_a, force_b, wr_data[7:6], wr_data[4:3]};

    genvar gc;
    generate
        for (gc = 0; gc < 2; gc++) begin : g_cmp
            cmp_match_fsm #(.W(W)) u_cmp (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .count   (count),
                .cmp_val (cmp_vals[gc]),
                .set_o   (cmp_set[gc])
            );
        end
    endgenerate

    assign cap_src = top_is_cap ? (count == cap_value) : cap_evt;

    always_comb begin
        set_vec          = '0;
        set_vec[FI_OVF]  = tick && ovf_evt;
        set_vec[FI_CMPA] = cmp_set[0];
        set_vec[FI_CMPB] = cmp_set[1];
        set_vec[FI_CAP]  = tick && cap_src;
    end

    always_comb begin
        wr_clr          = '0;
        wr_clr[FI_OVF]  = wr_data[RB_OVF];
        wr_clr[FI_CMPA] = wr_data[RB_CMPA];
        wr_clr[FI_CMPB] = wr_data[RB_CMPB];
        wr_clr[FI_CAP]  = wr_data[RB_CAP];
        if (!wr_en) wr_clr = '0;
    end

    assign clr_vec = ack | wr_clr;

    genvar gf;
    generate
        for (gf = 0; gf < NUM_FLAGS; gf++) begin : g_flag
            flag_cell u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[gf]),
                .clr_i  (clr_vec[gf]),
                .flag_o (flag_vec[gf])
            );
        end
    endgenerate

    always_comb begin
        flags          = '0;
        flags[RB_OVF]  = flag_vec[FI_OVF];
        flags[RB_CMPA] = flag_vec[FI_CMPA];
        flags[RB_CMPB] = flag_vec[FI_CMPB];
        flags[RB_CAP]  = flag_vec[FI_CAP];
    end

    assign irq = flag_vec & irq_mask;

    // R11
    no_set_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((flags & ~$past(flags)) == '0));

    // R6
    force_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_a && !cmp_set[0] && !flag_vec[FI_CMPA]) |=> !flag_vec[FI_CMPA]);

    // R4
    cap_top_ignores_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_is_cap && (count != cap_value) && !flag_vec[FI_CAP]) |=> !flag_vec[FI_CAP]);
endmodule

// File: tb/timer_flag_reg_test.sv
`timescale 1ns/100ps
module timer_flag_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick, top_is_cap, cap_evt, ovf_evt, force_a, force_b, wr_en;
    logic [15:0] count, cmp_a, cmp_b, cap_value;
    logic [3:0]  ack, irq_mask;
    logic [7:0]  wr_data;
    logic [7:0]  flags;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    logic [3:0] m = '0;
    logic pa = 1'b0, pb = 1'b0;

    always #2.5 clk = ~clk;

    timer_flag_reg uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .cap_value(cap_value), .top_is_cap(top_is_cap),
        .cap_evt(cap_evt), .ovf_evt(ovf_evt), .force_a(force_a), .force_b(force_b),
        .ack(ack), .wr_en(wr_en), .wr_data(wr_data), .irq_mask(irq_mask),
        .flags(flags), .irq(irq)
    );

    function automatic logic [7:0] image(input logic [3:0] f);
        return {2'b00, f[3], 2'b00, f[2], f[1], f[0]};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        tick = 0; top_is_cap = 0; cap_evt = 0; ovf_evt = 0; force_a = 0; force_b = 0;
        wr_en = 0; wr_data = 0; ack = 0; count = 16'd100; cmp_a = 16'd200;
        cmp_b = 16'd300; cap_value = 16'd400; irq_mask = 4'hF;
    endtask

    task automatic step(input string tag);
        logic [3:0] s, c, nx;
        logic npa, npb;
        s[0] = tick & ovf_evt;
        s[1] = tick & pa;
        s[2] = tick & pb;
        s[3] = tick & (top_is_cap ? (count == cap_value) : cap_evt);
        c = ack | (wr_en ? {wr_data[5], wr_data[2], wr_data[1], wr_data[0]} : 4'h0);
        nx = (m & ~c) | s;
        npa = tick ? (count == cmp_a) : pa;
        npb = tick ? (count == cmp_b) : pb;
        @(posedge clk); #1;
        m = nx; pa = npa; pb = npb;
        check({tag, " flags"}, flags, image(m));
        check({tag, " irq"}, {4'h0, irq}, {4'h0, m & irq_mask});
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset flags", flags, 8'h00);
        check("R1 reset irq", {4'h0, irq}, 8'h00);

        // R5: equality tick does not set; non-enabled ticks do not count
        tick = 1; count = 16'd5; cmp_a = 16'd5; step("R5 eq");
        check("R5 eq cycle", flags, 8'h00);
        tick = 0; count = 16'd6; step("R5 no tick");
        check("R5 wait tick", flags, 8'h00);
        tick = 1; step("R5 next tick");
        check("R5 set", flags, 8'h02);

        // R6: force strobes alone never set
        idle(); wr_en = 1; wr_data = 8'hFF; step("R9 clear all");
        idle(); tick = 1; force_a = 1; force_b = 1;
        repeat (3) step("R6 force");
        check("R6 force", flags, 8'h00);

        // R7 and R8
        idle(); tick = 1; ovf_evt = 1; step("R7 ovf");
        check("R7 ovf", flags, 8'h01);
        idle(); ack = 4'b0001; step("R8 ack");
        check("R8 ack", flags, 8'h00);

        // R10: set beats simultaneous ack and write-one
        idle(); tick = 1; ovf_evt = 1; ack = 4'b0001; wr_en = 1; wr_data = 8'h01;
        step("R10 set wins");
        check("R10 set wins", flags, 8'h01);

        // R9: write zero keeps, write one clears
        idle(); wr_en = 1; wr_data = 8'h00; step("R9 zero");
        check("R9 zero keeps", flags, 8'h01);
        idle(); wr_en = 1; wr_data = 8'h01; step("R9 one");
        check("R9 one clears", flags, 8'h00);

        // R3 then R2
        idle(); tick = 1; cap_evt = 1; step("R3 cap");
        check("R3 cap", flags, 8'h20);
        idle(); wr_en = 1; wr_data = 8'hD8; step("R2 reserved");
        check("R2 reserved", flags, 8'h20);
        idle(); ack = 4'b1000; step("R8 ack cap");

        // R4: capture-top mode
        idle(); tick = 1; top_is_cap = 1; cap_evt = 1; count = 16'd7; cap_value = 16'd9;
        step("R4 strobe ignored");
        check("R4 strobe ignored", flags, 8'h00);
        cap_evt = 0; count = 16'd9; step("R4 top");
        check("R4 top", flags, 8'h20);

        // R11: nothing sets without tick
        idle(); wr_en = 1; wr_data = 8'hFF; step("R9 clear all");
        idle(); cap_evt = 1; ovf_evt = 1; count = 16'd200;
        repeat (2) step("R11 no tick");
        check("R11 no tick", flags, 8'h00);

        // R12: mask qualifies requests
        idle(); tick = 1; ovf_evt = 1; cap_evt = 1; irq_mask = 4'b0001; step("R12 mask");
        check("R12 irq", {4'h0, irq}, 8'h01);
        idle(); irq_mask = 4'b1000; #1;
        check("R12 irq mask swap", {4'h0, irq}, 8'h08);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            tick = ($urandom % 4) != 0;
            count = 16'($urandom % 6);
            cmp_a = 16'($urandom % 6);
            cmp_b = 16'($urandom % 6);
            cap_value = 16'($urandom % 6);
            top_is_cap = ($urandom % 3) == 0;
            cap_evt = ($urandom % 4) == 0;
            ovf_evt = ($urandom % 4) == 0;
            force_a = ($urandom % 3) == 0;
            force_b = ($urandom % 3) == 0;
            ack = 4'($urandom) & 4'($urandom);
            wr_en = ($urandom % 5) == 0;
            wr_data = 8'($urandom);
            irq_mask = 4'($urandom);
            step("random R3-model");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule